// File: doc/BRIEF.md
# Serial Ferroelectric Memory Emulator (SPI Slave)

This block is an SPI slave that answers like a small serial ferroelectric memory. It lets a host-side SPI controller be brought up against real command behaviour in simulation or on a prototype, with no memory device attached. It runs entirely in the system clock domain. SCK, the active-low select and MOSI pass through two-flop synchronizers, and the block works on the edges it detects after them. SCK must therefore run well below the system clock, with at least four system cycles per SCK half-period.

Each frame begins with an opcode byte, optionally followed by address and data bytes. A write-enable latch gates memory writes, and it can be read back through a status byte. Reads and writes target an internal byte array whose depth is a parameter. A hibernate command puts the block to sleep. The next select assertion wakes it, but the command in that wake-up frame is not executed. Opcodes that are not listed in the requirements are ignored.

Top module: `spi_fram_emu`

## Requirements
- R1: After reset, miso_o is 0, the write-enable latch is clear (status byte 0x00), and every memory byte reads 0x00.
- R2: A frame whose opcode is 0x06 sets the write-enable latch. A two-byte frame with opcode 0x05 then returns the status byte during its second byte, most significant bit first. The latch appears in status bit 1, so the value is 0x02 and all other status bits are 0.
- R3: A frame whose opcode is 0x04 clears the write-enable latch, so the status byte reads 0x00.
- R4: While the latch is set, a five-byte frame stores the fifth byte at the addressed location. The frame is opcode 0x02, then three address bytes with the high byte first, then the data byte. A five-byte frame with opcode 0x03 and the same address bytes returns that value on MISO during its fifth byte. A write leaves the latch set.
- R5: A write frame received while the write-enable latch is clear leaves memory unchanged.
- R6: The address is 20 bits: the upper four bits of the first address byte are ignored. Only the low log2(MEM_DEPTH) address bits select a byte, so higher address bits alias.
- R7: Raising the select mid-frame discards the partial frame. A write cut off before its data byte completes changes nothing, and the next frame is decoded from its first byte.
- R8: Opcode 0xB9 enters hibernate. The next falling edge of the select wakes the block, and the frame it opens is ignored, including its MISO output. The frame after that is executed normally.
- R9: Any other opcode (for example 0x9F or 0xBA) changes no state and keeps MISO at 0 for the whole frame.
- R10: MISO is 0 while the select is high, and also during opcode and address bytes. It changes only after falling SCK edges (SPI mode 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock from the host |
| cs_ni | input | 1 | SPI select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
The bench builds the block with MEM_DEPTH set to 16. This lets one sweep write and read back every byte location with arithmetically derived data. It also makes the aliasing of upper address bits reachable using a few chosen address patterns. With that small array, every command, the cut-off frame, hibernate with its wake-up frame, and unknown opcodes all fit inside one short run, and each is checked through MISO only.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STATUS  = 8'h05;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam int FRAME_BYTES = 5;
  localparam int ADDR_W      = 20;
  localparam int WEL_BIT     = 1;
endpackage

// File: rtl/spi_fram_sync.sv
module spi_fram_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
        prev_q <= RST_VAL[i];
      end else begin
        meta_q <= in_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[i] = sync_q;
    assign prev_o[i] = prev_q;
  end
endmodule

// File: rtl/spi_fram_mem.sv
module spi_fram_mem #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [DEPTH-1:0][7:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R5: a location changes only through an asserted write strobe
  assert_mem_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/spi_fram_emu.sv
module spi_fram_emu
  import spi_fram_pkg::*;
#(
  parameter int MEM_DEPTH = 64,
  localparam int IDX_W  = $clog2(MEM_DEPTH),
  localparam int BYTE_W = $clog2(FRAME_BYTES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  logic [2:0] pin_s, pin_p;
  logic sck_s, sck_p, cs_s, cs_p, mosi_s;
  logic sck_rise, sck_fall, cs_fall, byte_done, active;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic [6:0]        rx_sh;
  logic [7:0]        rx_byte, tx_sh, status, mem_rdata, opc_q;
  logic [ADDR_W-1:0] addr_q, addr_next;
  logic wel_q, hib_q, skip_q, miso_q, mem_we;

  spi_fram_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({mosi_i, cs_ni, sck_i}),
    .sync_o(pin_s),
    .prev_o(pin_p)
  );

  assign sck_s  = pin_s[0];
  assign sck_p  = pin_p[0];
  assign cs_s   = pin_s[1];
  assign cs_p   = pin_p[1];
  assign mosi_s = pin_s[2];

  assign sck_rise  = sck_s & ~sck_p & ~cs_s;
  assign sck_fall  = ~sck_s & sck_p & ~cs_s;
  assign cs_fall   = ~cs_s & cs_p;
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};
  assign active    = ~hib_q & ~skip_q & (byte_cnt < BYTE_W'(FRAME_BYTES));
  assign addr_next = {addr_q[ADDR_W-9:0], rx_byte};
  assign status    = 8'(wel_q) << WEL_BIT;
  assign mem_we    = byte_done && active && (byte_cnt == BYTE_W'(4)) &&
                     (opc_q == OP_WRITE) && wel_q;

  spi_fram_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .waddr_i(addr_q[IDX_W-1:0]),
    .wdata_i(rx_byte),
    .raddr_i(addr_next[IDX_W-1:0]),
    .rdata_o(mem_rdata)
  );

  // Frame counters: cleared whenever select is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
    end else if (cs_s) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
    end else if (sck_rise) begin
      rx_sh   <= {rx_sh[5:0], mosi_s};
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_done && byte_cnt < BYTE_W'(FRAME_BYTES)) byte_cnt <= byte_cnt + 1'b1;
    end
  end

  // Command decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      hib_q  <= 1'b0;
      skip_q <= 1'b0;
      opc_q  <= '0;
      addr_q <= '0;
    end else if (cs_fall) begin
      skip_q <= hib_q;  // wake-up frame is swallowed
      hib_q  <= 1'b0;
    end else if (byte_done && active) begin
      if (byte_cnt == '0) begin
        opc_q <= rx_byte;
        case (rx_byte)
          OP_WEL_SET: wel_q <= 1'b1;
          OP_WEL_CLR: wel_q <= 1'b0;
          OP_SLEEP:   hib_q <= 1'b1;
          default: ;
        endcase
      end else if (byte_cnt <= BYTE_W'(3)) begin
        addr_q <= addr_next;
      end
    end
  end

  // MISO: load at byte boundary, shift on falling SCK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (cs_s) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (byte_done && active && byte_cnt == '0 && rx_byte == OP_STATUS) begin
      tx_sh <= status;
    end else if (byte_done && active && byte_cnt == BYTE_W'(3) && opc_q == OP_READ) begin
      tx_sh <= mem_rdata;
    end else if (sck_fall) begin
      miso_q <= tx_sh[7];
      tx_sh  <= {tx_sh[6:0], 1'b0};
    end
  end

  assign miso_o = miso_q;

  assert_miso_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !miso_o);
  assert_counters_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (bit_cnt == '0 && byte_cnt == '0));
  assert_wel_only_on_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_done |=> $stable(wel_q));
  assert_wake_on_select_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hib_q) |-> $past(cs_fall));
  assert_miso_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_s) |=> $stable(miso_o));
endmodule

// File: tb/spi_fram_emu_bench.sv
module spi_fram_emu_bench;
  localparam int DEPTH = 16;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] tx [5];
  logic [7:0] rx [5];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fram_emu #(.MEM_DEPTH(DEPTH)) u_spi_fram_emu (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
    .mosi_i(mosi), .miso_o(miso)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic frame(input int nbits);
    for (int k = 0; k < 5; k++) rx[k] = 8'h00;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck  = 1'b0;
      mosi = tx[i / 8][7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      rx[i / 8][7 - (i % 8)] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    tx[0] = op;
    frame(8);
  endtask

  task automatic status_rd(output logic [7:0] s);
    tx[0] = 8'h05; tx[1] = 8'h00;
    frame(16);
    s = rx[1];
  endtask

  task automatic mem_op(input logic [7:0] op, input logic [7:0] a2, input logic [7:0] a1,
                        input logic [7:0] a0, input logic [7:0] d);
    tx[0] = op; tx[1] = a2; tx[2] = a1; tx[3] = a0; tx[4] = d;
    frame(40);
  endtask

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    check8(8'(miso), 8'h00, "R1 miso after reset");
    status_rd(s);
    check8(s, 8'h00, "R1 status after reset");
    for (int a = 0; a < DEPTH; a++) begin
      mem_op(8'h03, 8'h00, 8'h00, 8'(a), 8'h00);
      check8(rx[4], 8'h00, "R1 memory cleared");
    end
    // R2
    cmd(8'h06);
    status_rd(s);
    check8(s, 8'h02, "R2 latch set");
    check8(rx[0], 8'h00, "R10 quiet during opcode");
    // R4 sweep
    for (int a = 0; a < DEPTH; a++) mem_op(8'h02, 8'h00, 8'h00, 8'(a), pat(a));
    for (int a = 0; a < DEPTH; a++) begin
      mem_op(8'h03, 8'h00, 8'h00, 8'(a), 8'h00);
      check8(rx[4], pat(a), "R4 read back");
      check8(rx[0] | rx[1] | rx[2] | rx[3], 8'h00, "R10 quiet before data");
    end
    status_rd(s);
    check8(s, 8'h02, "R4 latch kept after write");
    // R6 padding nibble and aliasing
    mem_op(8'h02, 8'hF9, 8'hC3, 8'h76, 8'hE1);
    mem_op(8'h03, 8'h00, 8'h00, 8'h06, 8'h00);
    check8(rx[4], 8'hE1, "R6 alias write");
    mem_op(8'h03, 8'h53, 8'h21, 8'h56, 8'h00);
    check8(rx[4], 8'hE1, "R6 alias read");
    // R7 cut write
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h02; tx[4] = 8'h00;
    frame(36);
    mem_op(8'h03, 8'h00, 8'h00, 8'h02, 8'h00);
    check8(rx[4], pat(2), "R7 partial write discarded");
    status_rd(s);
    check8(s, 8'h02, "R7 next frame decoded");
    // R3, R5
    cmd(8'h04);
    status_rd(s);
    check8(s, 8'h00, "R3 latch cleared");
    mem_op(8'h02, 8'h00, 8'h00, 8'h09, 8'h00);
    mem_op(8'h03, 8'h00, 8'h00, 8'h09, 8'h00);
    check8(rx[4], pat(9), "R5 write blocked");
    // R8
    cmd(8'h06);
    cmd(8'hB9);
    status_rd(s);
    check8(s, 8'h00, "R8 wake frame ignored");
    status_rd(s);
    check8(s, 8'h02, "R8 awake after wake frame");
    cmd(8'hB9);
    cmd(8'h04);
    status_rd(s);
    check8(s, 8'h02, "R8 clear in wake frame ignored");
    // R9
    mem_op(8'h9F, 8'h00, 8'h00, 8'h00, 8'h00);
    check8(rx[0] | rx[1] | rx[2] | rx[3] | rx[4], 8'h00, "R9 unknown opcode quiet");
    cmd(8'hBA);
    status_rd(s);
    check8(s, 8'h02, "R9 no sleep, state kept");
    mem_op(8'h03, 8'h00, 8'h00, 8'h0F, 8'h00);
    check8(rx[4], pat(15), "R9 memory kept");
    check8(8'(miso), 8'h00, "R10 quiet with select high");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule